// File: doc/BRIEF.md
# Dual-Channel Serial Reset Controller

This block owns the configuration registers, the two read-only status bytes, the pending-interrupt flags and the pin-control outputs of a two-channel serial controller. It defines what that state looks like after a reset. Two reset sources exist, and their reach differs.

A software reset is a command byte written to the command register of one channel. It clears that channel on the following clock and leaves the other channel alone. The hardware reset is the active-low `rst_n` input, sampled on the clock. It clears both channels and also loads the shared interrupt vector register with its power-up value.

Each status byte is a mix of two kinds of bits. Some are reset constants. The modem bits are loaded from the inverted, synchronised levels of the clear-to-send and carrier-detect pins.

The serial transmit and receive datapaths sit outside this block. They feed it status updates through `sts_upd`, interrupt requests through `int_req`, and the raw transmit bit through `tx_ser`. Software reads every byte through a single combinational read port.

Top module: `dual_chan_rst_ctl`

## Requirements
- R1: A write of 0x18 to address 0 (the command register) of channel c, sampled at clock edge k, is not stored. The channel is unchanged after edge k and is reset at edge k+1. Any other value written to address 0 is stored and reads back.
- R2: A channel reset sets the channel's configuration registers (addresses 0 to 7) to 0x00. The other channel's registers keep their values.
- R3: A channel reset loads status byte 1 (address 9, read-only) with 0x01.
- R4: Status byte 0 (address 8, read-only) has this layout:
  - bit7 break, bit6 underrun, bit5 CTS, bit4 hunt, bit3 DCD, bit2 transmit-empty, bit1 interrupt-pending, bit0 receive-available.
  - After a channel reset, bits 6, 4 and 2 are 1 and bits 7 and 0 are 0.
  - Bit 5 is the inverse of `cts_pin` and bit 3 is the inverse of `dcd_pin`, both as seen through a two-flop synchroniser (pin levels two edges earlier).
- R5: The CTS and DCD status bits change only on a reset or on an `sts_upd` pulse. A pin change alone leaves them as they are.
- R6: Each `int_req` bit sets a sticky pending flag, shown on `int_pend`. Status bit 1 of a channel is the OR of that channel's flags. A channel reset clears only that channel's flags, and the reset wins over a request in the same cycle.
- R7: Register 1 (pin control) drives the channel pins as follows:
  - bit0 enables transmit, and `txd` is `tx_ser` when it is set and 1 otherwise.
  - bit1 drives `rts_n` low and bit2 drives `dtr_n` low.
  - bit3 sets `txc_oe` and bit4 sets `rxc_oe`.
  - bit5 clears `sync_oe`.
  - After a reset, `txd`, `rts_n`, `dtr_n` and `sync_oe` are 1, and `txc_oe` and `rxc_oe` are 0.
- R8: `rst_n` low at a clock edge resets both channels as in R2 to R7 and loads the vector register (address 10) with 0x0F.
- R9: The vector register can be written through either channel. It reads the same from both channels, and a channel reset leaves it unchanged.
- R10: Writes to address 8, address 9, or any address above 10 change nothing. An `sts_upd` pulse loads status byte 0 bits 7, 6, 4, 2 and 0 from `sts0_val`, and loads status byte 1 from `sts1_val`.
- R11: Register writes, status updates and interrupt requests aimed at a channel in the edge where its command reset takes effect are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_ch | input | 1 | Channel addressed by the read |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| int_req | input | 6 | Interrupt requests, 3 per channel, channel 0 in the low bits |
| int_pend | output | 6 | Pending interrupt flags, same layout as int_req |
| sts_upd | input | 2 | Per-channel status update strobe |
| sts0_val | input | 16 | Status byte 0 update value, one byte per channel |
| sts1_val | input | 16 | Status byte 1 update value, one byte per channel |
| cts_pin | input | 2 | Clear-to-send pin level per channel (active low) |
| dcd_pin | input | 2 | Carrier-detect pin level per channel (active low) |
| tx_ser | input | 2 | Serial bit from the transmitter per channel |
| txd | output | 2 | Serial data output, marking (1) when transmit is disabled |
| rts_n | output | 2 | Request-to-send, active low |
| dtr_n | output | 2 | Data-terminal-ready, active low |
| txc_oe | output | 2 | Transmit clock pin drive enable (0 = input) |
| rxc_oe | output | 2 | Receive clock pin drive enable (0 = input) |
| sync_oe | output | 2 | Sync pin drive enable (1 = output) |

## Verification
The bench targets four timing and scope corners:
- **The gap cycle after a reset command.** A design that applies the reset in the same cycle as the write, or a cycle too late, shows the wrong configuration byte in that cycle.
- **Scope of a channel reset.** A design that clears the wrong scope wipes the other channel's registers or its pending flags, or resets the vector register on a software reset.
- **Modem status capture.** A design that samples the CTS/DCD pins without the synchroniser delay, or without inverting them, reports the wrong status bits after a reset. A design that lets those bits follow the pins continuously fails the hold check.
- **Same-edge collisions.** A design that gives a write or an interrupt priority over a channel reset leaves stale data in a channel that should be clean.

// File: rtl/dcr_pkg.sv
// Package: shared constants and types for the dual-channel reset controller.
// Assumes byte-wide registers; bit positions here are decoded by software.
package dcr_pkg;

    localparam int BYTE_W = 8;

    // Command byte that requests a reset of the addressed channel
    localparam logic [BYTE_W-1:0] CMD_CHAN_RESET = 8'h18;
    // Vector register value after a hardware reset
    localparam logic [BYTE_W-1:0] VEC_HW_INIT    = 8'h0F;
    // Status byte 1 after any reset (all-sent bit set)
    localparam logic [BYTE_W-1:0] STS1_INIT      = 8'h01;

    // Status byte 0 bit positions
    localparam int S0_RX_AVAIL = 0;
    localparam int S0_INT_PEND = 1;
    localparam int S0_TX_EMPTY = 2;
    localparam int S0_DCD      = 3;
    localparam int S0_HUNT     = 4;
    localparam int S0_CTS      = 5;
    localparam int S0_UNDERRUN = 6;
    localparam int S0_BREAK    = 7;

    // Bits of status byte 0 that the datapath owns, and their reset value
    localparam logic [BYTE_W-1:0] S0_DP_MASK = 8'hD5;
    localparam logic [BYTE_W-1:0] S0_DP_INIT = 8'h54;

    // Pin control register bit positions
    localparam int PC_TX_EN   = 0;
    localparam int PC_RTS     = 1;
    localparam int PC_DTR     = 2;
    localparam int PC_TXC_DRV = 3;
    localparam int PC_RXC_DRV = 4;
    localparam int PC_SYNC_IN = 5;

    // Channel pin bundle
    typedef struct packed {
        logic txd;
        logic rts_n;
        logic dtr_n;
        logic txc_oe;
        logic rxc_oe;
        logic sync_oe;
    } pin_bus_t;

endpackage

// File: rtl/dcr_sync2.sv
// Module: two-flop synchroniser for asynchronous pin levels.
// Assumes each bit is independent; the flops carry no reset so that the
// true pin level is already available while the hardware reset is held.
module dcr_sync2 #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    // Two-stage capture of the asynchronous levels
    always_ff @(posedge clk) begin
        meta_q   <= async_in;
        stable_q <= meta_q;
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/dcr_vector.sv
// Module: shared interrupt vector register.
// Writable through either channel at VEC_ADDR. Only the hardware reset
// touches it; channel resets do not. Assumes synchronous active-low reset.
module dcr_vector
    import dcr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int VEC_ADDR = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] vec_q
);

    logic vec_we;

    assign vec_we = wr_en && (wr_addr == ADDR_W'(VEC_ADDR));

    // Hold the vector; load init on hardware reset, data on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= VEC_HW_INIT;
        end else if (vec_we) begin
            vec_q <= wr_data;
        end
    end

    // R8
    hw_vec_init_chk: assert property (@(posedge clk)
        !rst_n |=> (vec_q == VEC_HW_INIT));

    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == ADDR_W'(VEC_ADDR))) |=> $stable(vec_q));

endmodule

// File: rtl/dcr_channel.sv
// Module: per-channel register file, status bytes, pending interrupts and
// pin control, with software (command) and hardware reset.
// Assumes NUM_CFG >= 2 (address 0 is the command register and address 1 the
// pin control register) and that cts_sync/dcd_sync are already synchronised.
module dcr_channel
    import dcr_pkg::*;
#(
    parameter int NUM_CFG = 8,
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] int_req,
    input  logic               sts_upd,
    input  logic [BYTE_W-1:0]  sts0_val,
    input  logic [BYTE_W-1:0]  sts1_val,
    input  logic               cts_sync,
    input  logic               dcd_sync,
    input  logic               tx_ser,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic [NUM_SRC-1:0] pend,
    output pin_bus_t           pins
);

    localparam int STS0_ADDR = NUM_CFG;
    localparam int STS1_ADDR = NUM_CFG + 1;

    logic                      cmd_hit;
    logic                      rst_pend_q;
    logic                      clr;
    logic [NUM_CFG*BYTE_W-1:0] cfg_flat;
    logic [BYTE_W-1:0]         s0_dp_q;
    logic [BYTE_W-1:0]         s1_q;
    logic                      cts_q;
    logic                      dcd_q;
    logic [NUM_SRC-1:0]        pend_q;
    logic [BYTE_W-1:0]         s0_view;
    logic [BYTE_W-1:0]         pin_ctl;

    // Decode a reset command aimed at this channel
    assign cmd_hit = wr_en && wr_sel && (wr_addr == '0) && (wr_data == CMD_CHAN_RESET);

    // Either reset source clears the channel state on this edge
    assign clr = !rst_n || rst_pend_q;

    // Defer the command reset by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend_q <= 1'b0;
        end else begin
            rst_pend_q <= cmd_hit;
        end
    end

    // One byte register per configuration address
    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        logic              we;
        logic [BYTE_W-1:0] q;

        assign we = wr_en && wr_sel && (wr_addr == ADDR_W'(i)) && !cmd_hit;

        // Store the byte unless the channel is being reset
        always_ff @(posedge clk) begin
            if (clr) begin
                q <= '0;
            end else if (we) begin
                q <= wr_data;
            end
        end

        assign cfg_flat[i*BYTE_W +: BYTE_W] = q;
    end

    // Status bytes and latched modem bits
    always_ff @(posedge clk) begin
        if (clr) begin
            s0_dp_q <= S0_DP_INIT;
            s1_q    <= STS1_INIT;
            cts_q   <= ~cts_sync;
            dcd_q   <= ~dcd_sync;
        end else if (sts_upd) begin
            s0_dp_q <= sts0_val & S0_DP_MASK;
            s1_q    <= sts1_val;
            cts_q   <= ~cts_sync;
            dcd_q   <= ~dcd_sync;
        end
    end

    // Sticky pending interrupt flags
    always_ff @(posedge clk) begin
        if (clr) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_q | int_req;
        end
    end

    assign pend = pend_q;

    // Assemble the software view of status byte 0
    always_comb begin
        s0_view              = s0_dp_q;
        s0_view[S0_INT_PEND] = |pend_q;
        s0_view[S0_CTS]      = cts_q;
        s0_view[S0_DCD]      = dcd_q;
    end

    // Read mux over configuration and status addresses
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_byte = cfg_flat[i*BYTE_W +: BYTE_W];
            end
        end
        if (rd_addr == ADDR_W'(STS0_ADDR)) begin
            rd_byte = s0_view;
        end
        if (rd_addr == ADDR_W'(STS1_ADDR)) begin
            rd_byte = s1_q;
        end
    end

    // Channel pins from the pin control register
    assign pin_ctl = cfg_flat[BYTE_W +: BYTE_W];

    always_comb begin
        pins.txd     = pin_ctl[PC_TX_EN] ? tx_ser : 1'b1;
        pins.rts_n   = ~pin_ctl[PC_RTS];
        pins.dtr_n   = ~pin_ctl[PC_DTR];
        pins.txc_oe  = pin_ctl[PC_TXC_DRV];
        pins.rxc_oe  = pin_ctl[PC_RXC_DRV];
        pins.sync_oe = ~pin_ctl[PC_SYNC_IN];
    end

    // R1
    cmd_rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend_q |=> (cfg_flat == '0));

    // R3
    cmd_rst_sts1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend_q |=> (s1_q == STS1_INIT));

    // R4
    cmd_rst_sts0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend_q |=> (s0_dp_q == S0_DP_INIT && cts_q == !$past(cts_sync)
                        && dcd_q == !$past(dcd_sync)));

    // R5
    modem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pend_q && !sts_upd) |=> (cts_q == $past(cts_q) && dcd_q == $past(dcd_q)));

    // R6
    cmd_rst_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend_q |=> (pend_q == '0));

    // R7
    cmd_rst_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend_q |=> (pins.txd && pins.rts_n && pins.dtr_n && !pins.txc_oe
                        && !pins.rxc_oe && pins.sync_oe));

endmodule

// File: rtl/dual_chan_rst_ctl.sv
// Module: top of the dual-channel serial reset controller.
// Instantiates the modem pin synchroniser, the shared vector register and
// one channel block per channel, and muxes the read port.
// Assumes the address map: 0..NUM_CFG-1 configuration, NUM_CFG status 0,
// NUM_CFG+1 status 1, NUM_CFG+2 vector; that map must fit in ADDR_W bits.
module dual_chan_rst_ctl
    import dcr_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int NUM_SRC = 3,
    parameter int NUM_CFG = 8,
    parameter int ADDR_W  = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [CH_W-1:0]           rd_ch,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [BYTE_W-1:0]         rd_data,
    input  logic [NUM_CH*NUM_SRC-1:0] int_req,
    output logic [NUM_CH*NUM_SRC-1:0] int_pend,
    input  logic [NUM_CH-1:0]         sts_upd,
    input  logic [NUM_CH*BYTE_W-1:0]  sts0_val,
    input  logic [NUM_CH*BYTE_W-1:0]  sts1_val,
    input  logic [NUM_CH-1:0]         cts_pin,
    input  logic [NUM_CH-1:0]         dcd_pin,
    input  logic [NUM_CH-1:0]         tx_ser,
    output logic [NUM_CH-1:0]         txd,
    output logic [NUM_CH-1:0]         rts_n,
    output logic [NUM_CH-1:0]         dtr_n,
    output logic [NUM_CH-1:0]         txc_oe,
    output logic [NUM_CH-1:0]         rxc_oe,
    output logic [NUM_CH-1:0]         sync_oe
);

    localparam int VEC_ADDR = NUM_CFG + 2;

    logic [2*NUM_CH-1:0]        modem_sync;
    logic [BYTE_W-1:0]          vec_q;
    logic [NUM_CH*BYTE_W-1:0]   chan_rd;

    // Synchronise both modem inputs of every channel
    dcr_sync2 #(.WIDTH(2*NUM_CH)) u_sync (
        .clk      (clk),
        .async_in ({dcd_pin, cts_pin}),
        .sync_out (modem_sync)
    );

    dcr_vector #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .vec_q   (vec_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pin_bus_t pins;

        dcr_channel #(
            .NUM_CFG (NUM_CFG),
            .NUM_SRC (NUM_SRC),
            .ADDR_W  (ADDR_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_sel   (wr_ch == CH_W'(c)),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .int_req  (int_req[c*NUM_SRC +: NUM_SRC]),
            .sts_upd  (sts_upd[c]),
            .sts0_val (sts0_val[c*BYTE_W +: BYTE_W]),
            .sts1_val (sts1_val[c*BYTE_W +: BYTE_W]),
            .cts_sync (modem_sync[c]),
            .dcd_sync (modem_sync[NUM_CH + c]),
            .tx_ser   (tx_ser[c]),
            .rd_addr  (rd_addr),
            .rd_byte  (chan_rd[c*BYTE_W +: BYTE_W]),
            .pend     (int_pend[c*NUM_SRC +: NUM_SRC]),
            .pins     (pins)
        );

        assign txd[c]     = pins.txd;
        assign rts_n[c]   = pins.rts_n;
        assign dtr_n[c]   = pins.dtr_n;
        assign txc_oe[c]  = pins.txc_oe;
        assign rxc_oe[c]  = pins.rxc_oe;
        assign sync_oe[c] = pins.sync_oe;
    end

    // Select the addressed channel, or the shared vector
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_ch == CH_W'(c)) begin
                rd_data = chan_rd[c*BYTE_W +: BYTE_W];
            end
        end
        if (rd_addr == ADDR_W'(VEC_ADDR)) begin
            rd_data = vec_q;
        end
    end

endmodule

// File: tb/tb_dual_chan_rst_ctl.sv
module tb_dual_chan_rst_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 2;
    localparam int NSRC = 3;
    localparam int NCFG = 8;
    localparam int AW   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [0:0]        wr_ch;
    logic [AW-1:0]     wr_addr;
    logic [7:0]        wr_data;
    logic [0:0]        rd_ch;
    logic [AW-1:0]     rd_addr;
    logic [7:0]        rd_data;
    logic [NCH*NSRC-1:0] int_req;
    logic [NCH*NSRC-1:0] int_pend;
    logic [NCH-1:0]    sts_upd;
    logic [NCH*8-1:0]  sts0_val;
    logic [NCH*8-1:0]  sts1_val;
    logic [NCH-1:0]    cts_pin;
    logic [NCH-1:0]    dcd_pin;
    logic [NCH-1:0]    tx_ser;
    logic [NCH-1:0]    txd, rts_n, dtr_n, txc_oe, rxc_oe, sync_oe;

    dual_chan_rst_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_ch(rd_ch), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_req(int_req), .int_pend(int_pend),
        .sts_upd(sts_upd), .sts0_val(sts0_val), .sts1_val(sts1_val),
        .cts_pin(cts_pin), .dcd_pin(dcd_pin), .tx_ser(tx_ser), .txd(txd),
        .rts_n(rts_n), .dtr_n(dtr_n), .txc_oe(txc_oe), .rxc_oe(rxc_oe),
        .sync_oe(sync_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  sweep_en = 1'b0;
    bit  done = 1'b0;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]      m_cfg [NCH][NCFG];
    logic [7:0]      m_s0dp [NCH];
    logic [7:0]      m_s1 [NCH];
    logic            m_cts [NCH];
    logic            m_dcd [NCH];
    logic [NSRC-1:0] m_pend [NCH];
    logic            m_rstq [NCH];
    logic [7:0]      m_vec;
    logic [NCH-1:0]  p1c = '0, p2c = '0, p1d = '0, p2d = '0;
    bit              m_valid = 1'b0;

    function automatic void m_reset(int c);
        for (int a = 0; a < NCFG; a++) m_cfg[c][a] = 8'h00;
        m_s0dp[c] = 8'h54;
        m_s1[c]   = 8'h01;
        m_cts[c]  = ~p2c[c];
        m_dcd[c]  = ~p2d[c];
        m_pend[c] = '0;
    endfunction

    always @(posedge clk) begin
        logic [NCH-1:0] hit;
        for (int c = 0; c < NCH; c++)
            hit[c] = rst_n && wr_en && (int'(wr_ch) == c) && (wr_addr == 0) && (wr_data == 8'h18);
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) m_reset(c);
            m_vec   = 8'h0F;
            m_valid = 1'b1;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m_rstq[c]) begin
                    m_reset(c);
                end else begin
                    if (wr_en && int'(wr_ch) == c && int'(wr_addr) < NCFG && !hit[c])
                        m_cfg[c][int'(wr_addr)] = wr_data;
                    m_pend[c] = m_pend[c] | int_req[c*NSRC +: NSRC];
                    if (sts_upd[c]) begin
                        m_s0dp[c] = sts0_val[c*8 +: 8] & 8'hD5;
                        m_s1[c]   = sts1_val[c*8 +: 8];
                        m_cts[c]  = ~p2c[c];
                        m_dcd[c]  = ~p2d[c];
                    end
                end
            end
            if (wr_en && wr_addr == 4'd10) m_vec = wr_data;
        end
        for (int c = 0; c < NCH; c++) m_rstq[c] = hit[c];
        p2c = p1c; p1c = cts_pin;
        p2d = p1d; p1d = dcd_pin;
    end

    function automatic logic [7:0] exp_rd(int c, int a);
        if (a < NCFG) return m_cfg[c][a];
        if (a == 8) return {m_s0dp[c][7], m_s0dp[c][6], m_cts[c], m_s0dp[c][4],
                            m_dcd[c], m_s0dp[c][2], |m_pend[c], m_s0dp[c][0]};
        if (a == 9) return m_s1[c];
        if (a == 10) return m_vec;
        return 8'h00;
    endfunction

    function automatic logic [5:0] exp_pins(int c);
        logic [7:0] pc = m_cfg[c][1];
        return {pc[0] ? tx_ser[c] : 1'b1, ~pc[1], ~pc[2], pc[3], pc[4], ~pc[5]};
    endfunction

    function automatic string rd_tag(int a);
        if (a < NCFG) return "R2";
        if (a == 8) return "R4";
        if (a == 9) return "R3";
        if (a == 10) return "R9";
        return "R10";
    endfunction

    // Compare every output with the model on every clock (R2 R3 R4 R6 R7 R9 R10)
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check(rd_tag(int'(rd_addr)), rd_data, exp_rd(int'(rd_ch), int'(rd_addr)), "model rd_data");
            for (int c = 0; c < NCH; c++) begin
                check("R7", {txd[c], rts_n[c], dtr_n[c], txc_oe[c], rxc_oe[c], sync_oe[c]},
                      exp_pins(c), "model pins");
                check("R6", int_pend[c*NSRC +: NSRC], m_pend[c], "model int_pend");
            end
        end
    end

    // Read-address sweeper for the model comparison
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sweep_en) begin
                rd_addr = AW'($urandom_range(0, 12));
                rd_ch   = 1'($urandom_range(0, 1));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(int c, int a, logic [7:0] d);
        wr_en = 1'b1; wr_ch = 1'(c); wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(int c, int a, logic [7:0] exp, string tag);
        sweep_en = 1'b0;
        rd_ch = 1'(c); rd_addr = AW'(a);
        #1;
        check(tag, rd_data, exp, "directed read");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    // ---------------- directed and random scenario ----------------
    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_addr = '0; wr_data = '0;
        rd_ch = '0; rd_addr = '0; int_req = '0; sts_upd = '0;
        sts0_val = '0; sts1_val = '0; cts_pin = 2'b01; dcd_pin = 2'b10; tx_ser = '0;
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R8: hardware reset values, modem bits from inverted pins
        chk_rd(0, 10, 8'h0F, "R8");
        chk_rd(0, 8, 8'h5C, "R8");
        chk_rd(1, 8, 8'h74, "R8");
        chk_rd(1, 9, 8'h01, "R3");
        check("R7", {txd[0], rts_n[0], dtr_n[0], txc_oe[0], rxc_oe[0], sync_oe[0]}, 6'b111001, "reset pins");
        step();

        wr(0, 1, 8'h3F);
        wr(0, 3, 8'hC3);
        wr(1, 1, 8'h21);
        wr(1, 5, 8'h9A);
        wr(1, 10, 8'hA5);
        int_req = 6'b101_011;
        tx_ser  = 2'b01;
        step();
        int_req = '0;
        chk_rd(0, 1, 8'h3F, "R2");
        chk_rd(0, 10, 8'hA5, "R9");
        check("R7", {txd[0], rts_n[0], dtr_n[0], txc_oe[0], sync_oe[0]}, 5'b10010, "pins driven");
        tx_ser = 2'b00;
        chk_rd(0, 8, 8'h5E, "R6");
        check("R7", txd[0], 1'b0, "txd follows tx_ser");
        step();

        // R5: pin change without update holds the status bits
        cts_pin = 2'b10;
        repeat (4) step();
        chk_rd(0, 8, 8'h5E, "R5");
        sts_upd = 2'b01; sts0_val = 16'h00FF; sts1_val = 16'h0080;
        step();
        sts_upd = '0;
        chk_rd(0, 8, 8'hFF, "R5");
        chk_rd(0, 9, 8'h80, "R10");
        step();

        // R10: read-only and unmapped addresses ignore writes
        wr(0, 8, 8'h00);
        wr(0, 9, 8'h00);
        wr(0, 12, 8'h55);
        chk_rd(0, 8, 8'hFF, "R10");
        chk_rd(0, 9, 8'h80, "R10");
        chk_rd(0, 12, 8'h00, "R10");
        step();

        // R1: ordinary command byte is stored
        wr(0, 0, 8'h05);
        chk_rd(0, 0, 8'h05, "R1");

        // R1: reset command, one clock of delay
        wr(0, 0, 8'h18);
        chk_rd(0, 1, 8'h3F, "R1");
        chk_rd(0, 0, 8'h05, "R1");
        step();
        chk_rd(0, 0, 8'h00, "R1");
        chk_rd(0, 1, 8'h00, "R2");
        chk_rd(0, 3, 8'h00, "R2");
        chk_rd(1, 5, 8'h9A, "R2");
        step();
        chk_rd(0, 10, 8'hA5, "R9");
        chk_rd(0, 9, 8'h01, "R3");
        chk_rd(0, 8, 8'h7C, "R4");
        check("R6", int_pend, 6'b101_000, "other channel pending kept");
        check("R7", {txd[0], rts_n[0], dtr_n[0], txc_oe[0], rxc_oe[0], sync_oe[0]}, 6'b111001, "chan reset pins");
        step();

        // R11: write and interrupt in the reset edge are discarded
        wr_en = 1'b1; wr_ch = 1'b1; wr_addr = 4'd0; wr_data = 8'h18;
        step();
        wr_addr = 4'd2; wr_data = 8'h77; int_req = 6'b111_000;
        step();
        wr_en = 1'b0; int_req = '0;
        chk_rd(1, 2, 8'h00, "R11");
        check("R11", int_pend[5:3], 3'b000, "pending after reset edge");
        chk_rd(1, 10, 8'hA5, "R9");
        step();

        // R8: hardware reset mid-run
        wr(0, 10, 8'h3C);
        wr(1, 4, 8'h44);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk_rd(0, 10, 8'h0F, "R8");
        chk_rd(1, 4, 8'h00, "R8");
        step();

        // Random traffic compared against the model every clock
        sweep_en = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            wr_en   = ($urandom_range(0, 1) == 0);
            wr_ch   = 1'($urandom_range(0, 1));
            wr_addr = AW'($urandom_range(0, 12));
            wr_data = ($urandom_range(0, 5) == 0) ? 8'h18 : 8'($urandom);
            if ($urandom_range(0, 9) == 0) wr_addr = 4'd0;
            int_req = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'b0;
            sts_upd = ($urandom_range(0, 5) == 0) ? 2'($urandom) : 2'b0;
            sts0_val = 16'($urandom);
            sts1_val = 16'($urandom);
            if ($urandom_range(0, 3) == 0) cts_pin = 2'($urandom);
            if ($urandom_range(0, 3) == 0) dcd_pin = 2'($urandom);
            tx_ser  = 2'($urandom);
            rst_n   = ($urandom_range(0, 199) != 0);
            step();
        end
        wr_en = 1'b0; int_req = '0; sts_upd = '0; rst_n = 1'b1;
        repeat (4) step();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule